// File: doc/BRIEF.md
# Multiplexed-Bus Device Select Decoder

This block sits beside a host whose external bus shares its pins between address and data. An access has two phases. In the first, the host raises the latch strobe and drives a full 32-bit address on the shared pins while its own bus select stays inactive. In the second, the latch strobe is low and the host select is active while the pins carry data. The decoder keeps the address from the first phase and compares it against six fixed 256-byte device windows. It then drives one active-low select to the device that owns the address, and only while the second phase is in progress.

Software always uses a single host select, and the device is picked by address alone. The decode therefore works on the captured address and never on the live pins, which no longer hold the address once the data phase begins. The captured address is also driven out, so the peripherals get a stable address and an 8-bit in-device offset.

Top module: `mbd_cs_decoder`

## Requirements
- R1: On every clock edge where `ale` is high, `lat_addr` loads the value on `ad`. While `ale` is low, `lat_addr` keeps its value.
- R2: `dev_cs_n[i]` is low exactly when all three hold: the captured address falls in window i, `host_cs_n` is low, and `ale` is low.
- R3: Window i begins at 0x48000000 plus an offset. The offsets for i = 0..5 are 0x00000, 0x40000, 0x80000, 0xA0000, 0xC0000 and 0xE0000. Each window is 0x100 bytes. Bits 31..18 and bits 17..8 of the captured address must equal those bits of the window base. Bits 7..0 play no part in the decode and appear unchanged on `lat_addr[7:0]`.
- R4: An address outside all six windows leaves every `dev_cs_n` high, even in the data phase. Examples are 0x48000100, 0x48020000 and 0x49000000.
- R5: At no time is more than one bit of `dev_cs_n` low.
- R6: While `ale` is high, every `dev_cs_n` bit is high, even if `host_cs_n` is still low from the access before.
- R7: While `host_cs_n` is high, every `dev_cs_n` bit is high.
- R8: While `rst_n` is low, every `dev_cs_n` bit is high. After reset, `lat_addr` is 0.
- R9: During the data phase, changes on `ad` do not affect `lat_addr` or the selects.
- R10: In a back-to-back access, the new latch phase captures the new address. When the new data phase begins, the select moves to the new device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad | input | 32 | Shared address/data pins |
| ale | input | 1 | Address latch strobe, active high |
| host_cs_n | input | 1 | Host bus select, active low, marks the data phase |
| lat_addr | output | 32 | Captured address driven to the peripherals |
| dev_cs_n | output | 6 | Per-device selects, active low, bit i for window i |

## Verification
Recapture and select gating can fall in the same cycle. This happens in a back-to-back access, where the host raises `ale` again while `host_cs_n` is still low from the previous data phase. At that point the register loads the new address, and the old select must close at once rather than follow either address. The bench provokes this with access pairs that move between windows and from a window to an unmapped address. Its reference model recomputes the expected selects every cycle, so it can judge that the selects stay high through the strobe cycle and that the new select opens in the first cycle after it.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  // Offset of device window idx above the region base.
  // The first three windows are spaced by 256 KiB; the rest by 128 KiB from 512 KiB.
  function automatic logic [31:0] win_offset(int unsigned idx);
    if (idx < 3) return 32'(idx) * 32'h0004_0000;
    else         return 32'h0008_0000 + 32'(idx - 2) * 32'h0002_0000;
  endfunction

endpackage

// File: rtl/mbd_addr_capture.sv
module mbd_addr_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [ADDR_W-1:0] ad,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ale_fall
);

  logic ale_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      ale_q  <= 1'b0;
    end else begin
      ale_q <= ale;
      if (ale) addr_q <= ad;
    end
  end

  // First data-phase cycle: strobe was high last cycle and is low now
  assign ale_fall = ale_q & ~ale;

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (addr_q == $past(ad)));  // R1
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(addr_q));  // R9

endmodule

// File: rtl/mbd_win_match.sv
module mbd_win_match
  import mbd_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          N_DEV       = 6,
  parameter int          OFF_W       = 8,
  parameter int          REGION_LSB  = 18,
  parameter logic [31:0] REGION_BASE = 32'h4800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_DEV-1:0]  hit
);

  localparam int HI_W  = ADDR_W - REGION_LSB;
  localparam int MID_W = REGION_LSB - OFF_W;

  for (genvar gi = 0; gi < N_DEV; gi++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(REGION_BASE + win_offset(gi));
    logic hi_hit, mid_hit;
    assign hi_hit  = (addr[ADDR_W-1:REGION_LSB] == BASE[ADDR_W-1:REGION_LSB]);
    assign mid_hit = (addr[REGION_LSB-1:OFF_W]  == BASE[REGION_LSB-1:OFF_W]);
    assign hit[gi] = hi_hit & mid_hit;
  end

  AST_WIN_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));  // R5

  logic unused_w;
  assign unused_w = ^{HI_W[0], MID_W[0]};

endmodule

// File: rtl/mbd_sel_gate.sv
module mbd_sel_gate #(
  parameter int N_DEV = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] hit,
  input  logic             ale,
  input  logic             host_cs_n,
  output logic [N_DEV-1:0] dev_cs_n
);

  logic sel_open;

  // Data phase: out of reset, strobe low, host select active
  assign sel_open = rst_n & ~ale & ~host_cs_n;
  assign dev_cs_n = ~(hit & {N_DEV{sel_open}});

  AST_NO_SEL_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (&dev_cs_n));  // R6
  AST_NO_SEL_HOST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_cs_n |-> (&dev_cs_n));  // R7

endmodule

// File: rtl/mbd_cs_decoder.sv
module mbd_cs_decoder
  import mbd_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          N_DEV       = 6,
  parameter int          OFF_W       = 8,
  parameter int          REGION_LSB  = 18,
  parameter logic [31:0] REGION_BASE = 32'h4800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ad,
  input  logic              ale,
  input  logic              host_cs_n,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [N_DEV-1:0]  dev_cs_n
);

  logic [ADDR_W-1:0] addr_q;
  logic              ale_fall;
  logic [N_DEV-1:0]  hit;

  mbd_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad(ad),
    .addr_q(addr_q), .ale_fall(ale_fall)
  );

  mbd_win_match #(
    .ADDR_W(ADDR_W), .N_DEV(N_DEV), .OFF_W(OFF_W),
    .REGION_LSB(REGION_LSB), .REGION_BASE(REGION_BASE)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .addr(addr_q), .hit(hit)
  );

  mbd_sel_gate #(.N_DEV(N_DEV)) u_gate (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ale(ale),
    .host_cs_n(host_cs_n), .dev_cs_n(dev_cs_n)
  );

  assign lat_addr = addr_q;

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dev_cs_n));  // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (&dev_cs_n));  // R8
  AST_SEL_NEEDS_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(&dev_cs_n) |-> (!ale && !host_cs_n));  // R2
  AST_SEL_OPENS_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_fall && !host_cs_n && (|hit)) |-> !(&dev_cs_n));  // R10

endmodule

// File: tb/tb_mbd_cs_decoder.sv
`timescale 1ns/1ps
module tb_mbd_cs_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic        ale = 1'b0;
  logic        host_cs_n = 1'b1;
  logic [31:0] lat_addr;
  logic [5:0]  dev_cs_n;

  int    checks = 0;
  int    errors = 0;
  string tag = "R8";
  bit    done = 0;

  logic [31:0] m_addr = '0;

  always #2.5 clk = ~clk;

  mbd_cs_decoder dut (
    .clk(clk), .rst_n(rst_n), .ad(ad), .ale(ale),
    .host_cs_n(host_cs_n), .lat_addr(lat_addr), .dev_cs_n(dev_cs_n)
  );

  function automatic logic [31:0] bench_base(int i);
    case (i)
      0: return 32'h4800_0000;
      1: return 32'h4804_0000;
      2: return 32'h4808_0000;
      3: return 32'h480A_0000;
      4: return 32'h480C_0000;
      default: return 32'h480E_0000;
    endcase
  endfunction

  function automatic logic [5:0] exp_sel_n(logic [31:0] a, logic r, logic l, logic c);
    logic [5:0] s = 6'h3F;
    for (int i = 0; i < 6; i++)
      if (r && !l && !c && (a >= bench_base(i)) && (a < bench_base(i) + 32'h100))
        s[i] = 1'b0;
    return s;
  endfunction

  // Reference model: address register behaviour
  always @(posedge clk) begin
    if (!rst_n) m_addr <= '0;
    else if (ale) m_addr <= ad;
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    logic [5:0] e;
    if (!done) begin
      e = exp_sel_n(m_addr, rst_n, ale, host_cs_n);
      checks++;
      if (dev_cs_n !== e) begin
        errors++;
        $display("FAIL %s dev_cs_n actual=%b expected=%b addr=%h", tag, dev_cs_n, e, m_addr);
      end
      checks++;
      if (lat_addr !== m_addr) begin
        errors++;
        $display("FAIL R1 lat_addr actual=%h expected=%h", lat_addr, m_addr);
      end
      checks++;
      if ($countones(~dev_cs_n) > 1) begin
        errors++;
        $display("FAIL R5 selects actual=%b expected=at most one low", dev_cs_n);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // One complete access; data changes mid data phase (R9)
  task automatic access(logic [31:0] a, string t);
    tag = t;
    ale = 1'b1; host_cs_n = 1'b1; ad = a; step();
    ale = 1'b0; host_cs_n = 1'b0; ad = 32'hDEAD_0000 ^ a; step();
    ad = ~a; step();
    ad = 32'h4804_0000; step();
    host_cs_n = 1'b1; step();
  endtask

  // Latch phase opened while the host select is still low (R6, R10)
  task automatic back_to_back(logic [31:0] a, logic [31:0] b);
    tag = "R10";
    ale = 1'b1; host_cs_n = 1'b1; ad = a; step();
    ale = 1'b0; host_cs_n = 1'b0; ad = 32'h1111_1111; step();
    tag = "R6";
    ale = 1'b1; ad = b; step();
    tag = "R10";
    ale = 1'b0; ad = 32'h2222_2222; step();
    step();
    host_cs_n = 1'b1; step();
  endtask

  initial begin
    tag = "R8";
    repeat (3) step();
    // Reset with host in an apparent data phase: selects stay high (R8)
    host_cs_n = 1'b0; step();
    rst_n = 1'b1; host_cs_n = 1'b1; step();
    tag = "R8"; step();
    for (int i = 0; i < 6; i++) access(bench_base(i) + 32'(i * 37), "R2");
    access(32'h4808_00FF, "R3");
    access(32'h480E_0001, "R3");
    access(32'h4800_0100, "R4");
    access(32'h4802_0000, "R4");
    access(32'h4900_0000, "R4");
    access(32'h480B_0000, "R4");
    back_to_back(32'h4800_0010, 32'h480C_0020);
    back_to_back(32'h480A_0000, 32'h4801_0000);
    back_to_back(32'h4801_0000, 32'h480E_00FF);
    // Host select inactive with strobe low: no select (R7)
    tag = "R7";
    ale = 1'b1; ad = 32'h4804_0044; step();
    ale = 1'b0; host_cs_n = 1'b1; ad = 32'h0; step(); step();
    // Latch strobe held several cycles, last value wins (R1)
    tag = "R1";
    ale = 1'b1; ad = 32'h4800_0001; step();
    ad = 32'h480C_0002; step();
    ale = 1'b0; host_cs_n = 1'b0; ad = 32'h0; step(); step();
    host_cs_n = 1'b1; step();
    // Reset again mid-stream (R8)
    tag = "R8";
    rst_n = 1'b0; host_cs_n = 1'b0; step(); step();
    rst_n = 1'b1; host_cs_n = 1'b1; step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule